// File: doc/BRIEF.md
# Per-Thread Scoreboard Token Tracker

This block records which long-latency operations are still in flight for each hardware thread of a vector engine. A compiler assigns each such operation a scoreboard token. When the issuing instruction goes out, it marks its token busy. The memory or message return path later frees that token. A dependent instruction names the same token and is held until the token reads free.

Every thread owns its own fixed bank of 32 tokens, and that bank does not depend on how many threads are active. With ten threads the block holds 320 token bits. The issue stage uses the set port. The return path uses the clear port. The dependency check port answers stall or go within the same cycle. When a thread retires, a retire input wipes that thread's whole bank.

Top module: `sbt_top`

## Requirements
- R1: After reset every token of every thread reads free: `chkStall` is 0 for every pair, and `protoErr` is 0.
- R2: Each of the 10 threads has 32 tokens (token index 0..31). A token's state depends only on operations that name its own thread and token.
- R3: A set with `setValid`=1 on a free token makes that token busy from the clock edge that samples it.
- R4: A clear with `clrValid`=1 on a busy token makes it free from the clock edge that samples it.
- R5: `chkStall` is combinational. It is 1 exactly when the current state holds the token named by `chkThread`/`chkToken` busy. A thread index of 10 or more reads 0.
- R6: A set and a clear to the same free token in the same cycle leave it busy, and `protoErr` stays 0.
- R7: A set and a clear to the same busy token in the same cycle leave it free, and `protoErr` is raised.
- R8: A set to a token that is already busy leaves the state unchanged. It drives `protoErr` high for exactly the one cycle that follows the sampling edge.
- R9: A retire with `retireValid`=1 frees all 32 tokens of the named thread at the next edge and leaves other threads unchanged. A set or clear to that thread in the same cycle is dropped, and no error is raised.
- R10: A set, clear or retire whose thread index is 10 or more changes no state and raises no error.
- R11: A clear to a token that is already free has no effect and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setValid | input | 1 | Issue of a long-latency operation |
| setThread | input | 4 | Thread of the issuing operation |
| setToken | input | 5 | Token claimed by the issuing operation |
| clrValid | input | 1 | Completion from the return path |
| clrThread | input | 4 | Thread of the completion |
| clrToken | input | 5 | Token freed by the completion |
| retireValid | input | 1 | Thread retirement |
| retireThread | input | 4 | Thread whose tokens are wiped |
| chkThread | input | 4 | Thread of the dependency check |
| chkToken | input | 5 | Token named by the dependent instruction |
| chkStall | output | 1 | 1 = hold the dependent instruction, 0 = go |
| protoErr | output | 1 | One-cycle pulse after a duplicate set |

## Verification
A token bit stuck in the wrong state shows up on `chkStall` as soon as that pair is probed, in the same cycle. A stuck-busy token therefore hangs its dependent instruction, and a stuck-free token lets it race ahead of its data. A wrong state on the set target also shows one cycle later on `protoErr`: a missing pulse, or a pulse where none belongs. The bench keeps the state visible by probing random pairs every cycle. It also sweeps all 320 pairs after each directed corner, so that a leak into a neighbouring thread or token is found before the next stimulus.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  parameter int unsigned SBT_THREADS = 10;
  parameter int unsigned SBT_TOKENS  = 32;
  localparam int unsigned THR_W = $clog2(SBT_THREADS);
  localparam int unsigned TOK_W = $clog2(SBT_TOKENS);

  typedef logic [THR_W-1:0] thr_t;
  typedef logic [TOK_W-1:0] tok_t;
  typedef logic [SBT_THREADS-1:0][SBT_TOKENS-1:0] tok_state_t;

  // strobes from control to datapath, all one-hot or zero
  typedef struct packed {
    logic [SBT_THREADS-1:0] setThrMask;
    logic [SBT_TOKENS-1:0]  setTokMask;
    logic [SBT_THREADS-1:0] clrThrMask;
    logic [SBT_TOKENS-1:0]  clrTokMask;
    logic [SBT_THREADS-1:0] wipeMask;
  } sbt_strobe_t;
endpackage

// File: rtl/sbt_ctrl.sv
module sbt_ctrl
  import sbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        setValid,
  input  thr_t        setThread,
  input  tok_t        setToken,
  input  logic        clrValid,
  input  thr_t        clrThread,
  input  tok_t        clrToken,
  input  logic        retireValid,
  input  thr_t        retireThread,
  input  thr_t        chkThread,
  input  tok_t        chkToken,
  input  tok_state_t  tokState,
  output sbt_strobe_t strobe,
  output logic        chkStall,
  output logic        protoErr
);
  // thread index decode; indices past the last thread give all zeros
  function automatic logic [SBT_THREADS-1:0] thrHot(input thr_t idx, input logic en);
    logic [SBT_THREADS-1:0] hot;
    hot = '0;
    for (int i = 0; i < int'(SBT_THREADS); i++) begin
      if (en && (int'(idx) == i)) hot[i] = 1'b1;
    end
    return hot;
  endfunction

  logic [SBT_THREADS-1:0] retireHot, setHot, clrHot, chkHot;
  logic [SBT_THREADS-1:0] setCol, chkCol;
  logic                   setHit;
  logic                   protoErrQ;

  assign retireHot = thrHot(retireThread, retireValid);
  assign setHot    = thrHot(setThread, setValid) & ~retireHot;
  assign clrHot    = thrHot(clrThread, clrValid) & ~retireHot;
  assign chkHot    = thrHot(chkThread, 1'b1);

  // pick one token column out of every thread row
  for (genvar t = 0; t < int'(SBT_THREADS); t++) begin : g_col
    assign setCol[t] = tokState[t][setToken];
    assign chkCol[t] = tokState[t][chkToken];
  end

  // a set is a duplicate when its target is still busy
  assign setHit = |(setHot & setCol);

  always_comb begin
    strobe            = '0;
    strobe.wipeMask   = retireHot;
    strobe.setThrMask = setHit ? '0 : setHot;
    strobe.setTokMask = SBT_TOKENS'(1) << setToken;
    strobe.clrThrMask = clrHot;
    strobe.clrTokMask = SBT_TOKENS'(1) << clrToken;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protoErrQ <= 1'b0;
    else       protoErrQ <= setHit;
  end

  assign protoErr = protoErrQ;
  assign chkStall = |(chkHot & chkCol);
endmodule

// File: rtl/sbt_datapath.sv
module sbt_datapath
  import sbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  sbt_strobe_t strobe,
  output tok_state_t  tokState
);
  logic [SBT_TOKENS-1:0] rowQ [SBT_THREADS];

  for (genvar t = 0; t < int'(SBT_THREADS); t++) begin : g_row
    logic [SBT_TOKENS-1:0] clrBits, setBits, rowNext;

    assign clrBits = strobe.clrThrMask[t] ? strobe.clrTokMask : '0;
    assign setBits = strobe.setThrMask[t] ? strobe.setTokMask : '0;
    // clear first, then set: a fresh issue on a free token survives a stale clear
    assign rowNext = strobe.wipeMask[t] ? '0 : ((rowQ[t] & ~clrBits) | setBits);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rowQ[t] <= '0;
      else       rowQ[t] <= rowNext;
    end

    assign tokState[t] = rowQ[t];
  end
endmodule

// File: rtl/sbt_top.sv
module sbt_top
  import sbt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             setValid,
  input  logic [THR_W-1:0] setThread,
  input  logic [TOK_W-1:0] setToken,
  input  logic             clrValid,
  input  logic [THR_W-1:0] clrThread,
  input  logic [TOK_W-1:0] clrToken,
  input  logic             retireValid,
  input  logic [THR_W-1:0] retireThread,
  input  logic [THR_W-1:0] chkThread,
  input  logic [TOK_W-1:0] chkToken,
  output logic             chkStall,
  output logic             protoErr
);
  sbt_strobe_t strobe;
  tok_state_t  tokState;

  sbt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .setValid(setValid), .setThread(setThread), .setToken(setToken),
    .clrValid(clrValid), .clrThread(clrThread), .clrToken(clrToken),
    .retireValid(retireValid), .retireThread(retireThread),
    .chkThread(chkThread), .chkToken(chkToken),
    .tokState(tokState), .strobe(strobe),
    .chkStall(chkStall), .protoErr(protoErr)
  );

  sbt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tokState(tokState)
  );
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker
  import sbt_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       setValid,
  input thr_t       setThread,
  input tok_t       setToken,
  input logic       clrValid,
  input thr_t       clrThread,
  input tok_t       clrToken,
  input logic       retireValid,
  input thr_t       retireThread,
  input logic       protoErr,
  input tok_state_t tokState
);
  logic setOk, clrOk, retOk;
  assign setOk = setValid && (int'(setThread) < int'(SBT_THREADS))
                 && !(retireValid && retireThread == setThread);
  assign clrOk = clrValid && (int'(clrThread) < int'(SBT_THREADS))
                 && !(retireValid && retireThread == clrThread);
  assign retOk = retireValid && (int'(retireThread) < int'(SBT_THREADS));

  AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    setOk && !tokState[setThread][setToken]
    |=> tokState[$past(setThread)][$past(setToken)]);  // R3

  AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rstN)
    clrOk && tokState[clrThread][clrToken]
    && !(setOk && setThread == clrThread && setToken == clrToken && !tokState[setThread][setToken])
    |=> !tokState[$past(clrThread)][$past(clrToken)]);  // R4

  AST_DUP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    setOk && tokState[setThread][setToken] |=> protoErr);  // R8

  AST_NO_STRAY_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !setValid |=> !protoErr);  // R10

  AST_RETIRE_WIPES: assert property (@(posedge clk) disable iff (!rstN)
    retOk |=> (tokState[$past(retireThread)] == '0));  // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !setValid && !clrValid && !retireValid |=> $stable(tokState));  // R2
endmodule

bind sbt_top sbt_checker u_chk (.*);

// File: tb/sbt_top_tb_top.sv
`timescale 1ns/1ps
module sbt_top_tb_top;
  import sbt_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setValid = 0, clrValid = 0, retireValid = 0;
  thr_t setThread = '0, clrThread = '0, retireThread = '0, chkThread = '0;
  tok_t setToken = '0, clrToken = '0, chkToken = '0;
  logic chkStall, protoErr;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 0;
  bit [SBT_THREADS-1:0][SBT_TOKENS-1:0] mdl = '0;

  always #2.5 clk = ~clk;

  sbt_top dut_i (.*);

  task automatic expect1(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit refStall(input int thr, input int tok);
    if (thr >= int'(SBT_THREADS)) return 1'b0;
    return mdl[thr][tok];
  endfunction

  task automatic probe(input string req, input int thr, input int tok);
    chkThread = thr_t'(thr);
    chkToken  = tok_t'(tok);
    #0.2;
    expect1(req, $sformatf("stall t%0d k%0d", thr, tok), int'(chkStall), int'(refStall(thr, tok)));
  endtask

  task automatic sweep(input string req);
    for (int t = 0; t < int'(SBT_THREADS); t++)
      for (int k = 0; k < int'(SBT_TOKENS); k++)
        probe(req, t, k);
  endtask

  // one clock of stimulus; inputs driven at negedge, checked at the next negedge
  task automatic step(input string req,
                      input bit sv, input int st, input int sk,
                      input bit cv, input int ct, input int ck,
                      input bit rv, input int rt);
    bit [SBT_THREADS-1:0][SBT_TOKENS-1:0] nxt;
    bit expErr, doSet, retHere;
    setValid = sv; setThread = thr_t'(st); setToken = tok_t'(sk);
    clrValid = cv; clrThread = thr_t'(ct); clrToken = tok_t'(ck);
    retireValid = rv; retireThread = thr_t'(rt);
    nxt = mdl; expErr = 0; doSet = 0;
    retHere = rv && rt < int'(SBT_THREADS);
    if (retHere) nxt[rt] = '0;
    if (sv && st < int'(SBT_THREADS) && !(retHere && rt == st)) begin
      if (mdl[st][sk]) expErr = 1; else doSet = 1;
    end
    if (cv && ct < int'(SBT_THREADS) && !(retHere && rt == ct)) nxt[ct][ck] = 1'b0;
    if (doSet) nxt[st][sk] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    setValid = 0; clrValid = 0; retireValid = 0;
    mdl = nxt;
    expect1(req, "protoErr", int'(protoErr), int'(expErr));
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    expect1("R1", "protoErr after reset", int'(protoErr), 0);
    sweep("R1");

    // R5: combinational view before the edge, then R3 after it
    probe("R5", 2, 7);
    setValid = 1; setThread = 4'd2; setToken = 5'd7;
    probe("R5", 2, 7);
    step("R3", 1, 2, 7, 0, 0, 0, 0, 0);
    probe("R3", 2, 7);

    // R2: corner tokens of the outer threads, no leakage
    step("R2", 1, 9, 31, 0, 0, 0, 0, 0);
    step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
    sweep("R2");

    // R4: clear frees it
    step("R4", 0, 0, 0, 1, 2, 7, 0, 0);
    probe("R4", 2, 7);

    // R6: set + clear on a free token
    step("R6", 1, 4, 3, 1, 4, 3, 0, 0);
    probe("R6", 4, 3);
    // R7: set + clear on a busy token
    step("R7", 1, 4, 3, 1, 4, 3, 0, 0);
    probe("R7", 4, 3);

    // R8: duplicate set, pulse lasts one cycle, state kept
    step("R8", 1, 9, 31, 0, 0, 0, 0, 0);
    idle("R8");
    probe("R8", 9, 31);

    // R11: clear of a free token
    step("R11", 0, 0, 0, 1, 1, 1, 0, 0);
    sweep("R11");

    // R9: retire wipes one thread, overrides same-cycle set/clear
    step("R9", 1, 5, 1, 0, 0, 0, 0, 0);
    step("R9", 1, 5, 30, 0, 0, 0, 0, 0);
    step("R9", 1, 6, 1, 0, 0, 0, 0, 0);
    step("R9", 1, 5, 1, 1, 5, 30, 1, 5);
    sweep("R9");

    // R10: out-of-range thread indices
    step("R10", 1, 12, 4, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 1, 14, 31, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 1, 15);
    probe("R5", 10, 0);
    probe("R5", 15, 31);
    sweep("R10");

    // random mix with a narrow token range to force collisions
    for (int n = 0; n < 4000; n++) begin
      bit sv, cv, rv;
      int st, sk, ct, ck, rt;
      sv = ($urandom % 3) != 0;
      cv = ($urandom % 3) != 0;
      rv = ($urandom % 40) == 0;
      st = $urandom % 12; ct = $urandom % 12; rt = $urandom % 12;
      sk = (($urandom % 4) == 0) ? int'($urandom % 32) : int'($urandom % 3);
      ck = (($urandom % 4) == 0) ? int'($urandom % 32) : int'($urandom % 3);
      if (($urandom % 8) == 0) begin ct = st; ck = sk; end
      step("R8", sv, st, sk, cv, ct, ck, rv, rt);
      probe("R2", int'($urandom % 11), int'($urandom % 3));
      probe("R5", st, sk);
    end
    sweep("R2");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end
endmodule